// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block sits at the home node of a distributed shared-memory system and keeps coherence state for every memory block that lives at that node. For each block it holds one of three states and a presence vector with one bit per node. It also holds the block's memory data. Remote nodes send it read misses, write misses and writebacks on a request channel. It answers on a response channel with data replies, invalidations and fetch commands. Those commands go only to the nodes whose presence bits are set, so no miss is ever broadcast.

The controller handles one request at a time. A request is accepted only while the controller is idle. From acceptance until the transaction finishes, the request channel stays closed. Any later request, whether to the same block or another, waits at the sender until any outstanding invalidations or fetches are acknowledged. Remote nodes answer invalidations and fetches on an acknowledge channel. A fetch acknowledge carries the owner's current copy of the block. Every state change is caused by an incoming request; acknowledges only finish a transaction that is already open.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every block is Uncached with an empty presence vector and zero memory data, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A read miss (req_type 0) to an Uncached or Shared block produces exactly one reply (rsp_kind 0) to the requester carrying memory data. It leaves the block Shared with the requester's presence bit added.
- R3: A write miss (req_type 1) to an Uncached block produces only a reply to the requester and makes the requester the single owner of a Modified block.
- R4: A write miss to a Shared block sends one invalidate (rsp_kind 1) to each sharer other than the requester, one per cycle, in ascending node order. It then replies to the requester, who becomes the single owner.
- R5: A read miss to a Modified block sends a fetch (rsp_kind 2) to the owner. The acknowledge data is written to memory and returned in the reply. The block becomes Shared with both owner and requester present.
- R6: A write miss to a Modified block sends a fetch-and-invalidate (rsp_kind 3) to the owner. The acknowledge data is forwarded in the reply, and the requester becomes the single owner.
- R7: A writeback (req_type 2) from the owner of a Modified block writes its data to memory, makes the block Uncached with an empty presence vector, and produces no response.
- R8: A writeback from a node that is not the owner, or to a block that is not Modified, changes neither state nor memory and produces no response.
- R9: `req_ready` is 0 from the acceptance of a request until its transaction ends. A reply is not sent before every awaited node has acknowledged. An acknowledge from a node that is not awaited is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken on this edge |
| req_type | input | 2 | 0 read miss, 1 write miss, 2 writeback |
| req_node | input | NODE_W | Requesting node |
| req_addr | input | ADDR_W | Block index |
| req_data | input | DATA_W | Writeback data |
| rsp_valid | output | 1 | Response present (always accepted) |
| rsp_kind | output | 2 | 0 reply, 1 invalidate, 2 fetch, 3 fetch-and-invalidate |
| rsp_node | output | NODE_W | Destination node |
| rsp_addr | output | ADDR_W | Block index |
| rsp_data | output | DATA_W | Block data on replies, zero otherwise |
| ack_valid | input | 1 | Acknowledge from a remote node |
| ack_node | input | NODE_W | Acknowledging node |
| ack_data | input | DATA_W | Block data returned by a fetch |

## Verification
The bench targets a write miss where the requester is already a sharer. A design that forgets to mask the requester would invalidate the requester's own copy. It checks that presence vectors survive later transactions: after a read of a Modified block, a following write miss must invalidate both the old owner and the reader, and a design that drops either would leave a stale copy. Writebacks from non-owners and to Shared blocks are followed by reads. A design that trusted them would reply with the bogus data or skip the fetch from the true owner. Acknowledges are delayed, and a stray acknowledge from an unrelated node is injected. A controller that counted acknowledges rather than matching nodes would reply early or reopen the request channel too soon.

// File: rtl/dir_pkg.sv
package dir_pkg;

  typedef enum logic [1:0] {
    DS_UNC = 2'd0,
    DS_SHR = 2'd1,
    DS_MOD = 2'd2
  } dstate_t;

  localparam logic [1:0] RQ_READ  = 2'd0;
  localparam logic [1:0] RQ_WRITE = 2'd1;
  localparam logic [1:0] RQ_WBACK = 2'd2;

  localparam logic [1:0] RK_REPLY = 2'd0;
  localparam logic [1:0] RK_INV   = 2'd1;
  localparam logic [1:0] RK_FETCH = 2'd2;
  localparam logic [1:0] RK_FINV  = 2'd3;

endpackage

// File: rtl/dir_entry_store.sv
module dir_entry_store
  import dir_pkg::*;
#(
  parameter int NODE_CNT  = 4,
  parameter int BLOCK_CNT = 16,
  parameter int DATA_W    = 32,
  localparam int ADDR_W   = (BLOCK_CNT > 1) ? $clog2(BLOCK_CNT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  output dstate_t             rd_state,
  output logic [NODE_CNT-1:0] rd_shr,
  output logic [DATA_W-1:0]   rd_data,
  input  logic                ent_we,
  input  dstate_t             ent_state,
  input  logic [NODE_CNT-1:0] ent_shr,
  input  logic                mem_we,
  input  logic [DATA_W-1:0]   mem_wdata
);

  dstate_t             st_q  [BLOCK_CNT];
  logic [NODE_CNT-1:0] shr_q [BLOCK_CNT];
  logic [DATA_W-1:0]   dat_q [BLOCK_CNT];

  assign rd_state = st_q[addr];
  assign rd_shr   = shr_q[addr];
  assign rd_data  = dat_q[addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < BLOCK_CNT; b++) begin
        st_q[b]  <= DS_UNC;
        shr_q[b] <= '0;
      end
    end else if (ent_we) begin
      st_q[addr]  <= ent_state;
      shr_q[addr] <= ent_shr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < BLOCK_CNT; b++) dat_q[b] <= '0;
    end else if (mem_we) begin
      dat_q[addr] <= mem_wdata;
    end
  end

endmodule

// File: rtl/dir_plan.sv
module dir_plan
  import dir_pkg::*;
#(
  parameter int NODE_CNT = 4,
  localparam int NODE_W  = (NODE_CNT > 1) ? $clog2(NODE_CNT) : 1
) (
  input  dstate_t             cur_state,
  input  logic [NODE_CNT-1:0] cur_shr,
  input  logic [1:0]          rtype,
  input  logic [NODE_W-1:0]   rnode,
  output dstate_t             nxt_state,
  output logic [NODE_CNT-1:0] nxt_shr,
  output logic [NODE_CNT-1:0] targets,
  output logic [1:0]          tgt_kind,
  output logic                silent,
  output logic                wb_ok
);

  logic [NODE_CNT-1:0] self_bit;

  always_comb begin
    self_bit        = '0;
    self_bit[rnode] = 1'b1;
    nxt_state       = cur_state;
    nxt_shr         = cur_shr;
    targets         = '0;
    tgt_kind        = RK_INV;
    silent          = 1'b1;
    wb_ok           = 1'b0;
    case (rtype)
      RQ_READ: begin
        silent    = 1'b0;
        nxt_state = DS_SHR;
        nxt_shr   = cur_shr | self_bit;
        tgt_kind  = RK_FETCH;
        if (cur_state == DS_MOD) targets = cur_shr & ~self_bit;
      end
      RQ_WRITE: begin
        silent    = 1'b0;
        nxt_state = DS_MOD;
        nxt_shr   = self_bit;
        targets   = cur_shr & ~self_bit;
        tgt_kind  = (cur_state == DS_MOD) ? RK_FINV : RK_INV;
      end
      RQ_WBACK: begin
        wb_ok     = (cur_state == DS_MOD) && (cur_shr == self_bit);
        nxt_state = DS_UNC;
        nxt_shr   = '0;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/dir_target_pick.sv
module dir_target_pick #(
  parameter int NODE_CNT = 4,
  localparam int NODE_W  = (NODE_CNT > 1) ? $clog2(NODE_CNT) : 1
) (
  input  logic [NODE_CNT-1:0] vec,
  output logic                found,
  output logic [NODE_W-1:0]   idx,
  output logic [NODE_CNT-1:0] onehot
);

  logic [NODE_CNT:0] seen;

  assign seen[0] = 1'b0;

  for (genvar g = 0; g < NODE_CNT; g++) begin : g_chain
    assign onehot[g]  = vec[g] & ~seen[g];
    assign seen[g+1]  = seen[g] | vec[g];
  end

  assign found = seen[NODE_CNT];

  always_comb begin
    idx = '0;
    for (int i = 0; i < NODE_CNT; i++) begin
      if (onehot[i]) idx = idx | NODE_W'(i);
    end
  end

endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dir_pkg::*;
#(
  parameter int NODE_CNT  = 4,
  parameter int BLOCK_CNT = 16,
  parameter int DATA_W    = 32,
  localparam int NODE_W   = (NODE_CNT > 1) ? $clog2(NODE_CNT) : 1,
  localparam int ADDR_W   = (BLOCK_CNT > 1) ? $clog2(BLOCK_CNT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_type,
  input  logic [NODE_W-1:0] req_node,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              rsp_valid,
  output logic [1:0]        rsp_kind,
  output logic [NODE_W-1:0] rsp_node,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              ack_valid,
  input  logic [NODE_W-1:0] ack_node,
  input  logic [DATA_W-1:0] ack_data
);

  typedef enum logic [2:0] {
    F_IDLE  = 3'd0,
    F_EVAL  = 3'd1,
    F_SEND  = 3'd2,
    F_WAIT  = 3'd3,
    F_REPLY = 3'd4
  } fsm_t;

  fsm_t                fsm_q, fsm_d;
  logic [NODE_CNT-1:0] pend_q, pend_d;
  logic [NODE_CNT-1:0] outst_q, outst_d;

  logic [1:0]          r_type_q;
  logic [NODE_W-1:0]   r_node_q;
  logic [ADDR_W-1:0]   r_addr_q;
  logic [DATA_W-1:0]   r_data_q;
  dstate_t             plan_st_q;
  logic [NODE_CNT-1:0] plan_shr_q;
  logic [1:0]          kind_q;

  logic                cap_en, plan_en;

  dstate_t             rd_state;
  logic [NODE_CNT-1:0] rd_shr;
  logic [DATA_W-1:0]   rd_data;
  logic                ent_we, mem_we;
  dstate_t             ent_wstate;
  logic [NODE_CNT-1:0] ent_wshr;
  logic [DATA_W-1:0]   mem_wdata;

  dstate_t             p_state;
  logic [NODE_CNT-1:0] p_shr, p_targets;
  logic [1:0]          p_kind;
  logic                p_silent, p_wb_ok;

  logic                pick_found;
  logic [NODE_W-1:0]   pick_idx;
  logic [NODE_CNT-1:0] pick_oh;
  logic                ack_hit;

  dir_entry_store #(
    .NODE_CNT (NODE_CNT),
    .BLOCK_CNT(BLOCK_CNT),
    .DATA_W   (DATA_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (r_addr_q),
    .rd_state (rd_state),
    .rd_shr   (rd_shr),
    .rd_data  (rd_data),
    .ent_we   (ent_we),
    .ent_state(ent_wstate),
    .ent_shr  (ent_wshr),
    .mem_we   (mem_we),
    .mem_wdata(mem_wdata)
  );

  dir_plan #(.NODE_CNT(NODE_CNT)) u_plan (
    .cur_state(rd_state),
    .cur_shr  (rd_shr),
    .rtype    (r_type_q),
    .rnode    (r_node_q),
    .nxt_state(p_state),
    .nxt_shr  (p_shr),
    .targets  (p_targets),
    .tgt_kind (p_kind),
    .silent   (p_silent),
    .wb_ok    (p_wb_ok)
  );

  dir_target_pick #(.NODE_CNT(NODE_CNT)) u_pick (
    .vec   (pend_q),
    .found (pick_found),
    .idx   (pick_idx),
    .onehot(pick_oh)
  );

  assign ack_hit = ack_valid && outst_q[ack_node];

  always_comb begin
    fsm_d      = fsm_q;
    pend_d     = pend_q;
    outst_d    = outst_q;
    cap_en     = 1'b0;
    plan_en    = 1'b0;
    ent_we     = 1'b0;
    ent_wstate = plan_st_q;
    ent_wshr   = plan_shr_q;
    mem_we     = 1'b0;
    mem_wdata  = r_data_q;

    if (ack_hit) begin
      outst_d[ack_node] = 1'b0;
      if (kind_q == RK_FETCH || kind_q == RK_FINV) begin
        mem_we    = 1'b1;
        mem_wdata = ack_data;
      end
    end

    case (fsm_q)
      F_IDLE: begin
        if (req_valid) begin
          cap_en = 1'b1;
          fsm_d  = F_EVAL;
        end
      end
      F_EVAL: begin
        if (p_silent) begin
          if (p_wb_ok) begin
            ent_we     = 1'b1;
            ent_wstate = p_state;
            ent_wshr   = p_shr;
            mem_we     = 1'b1;
            mem_wdata  = r_data_q;
          end
          fsm_d = F_IDLE;
        end else begin
          plan_en = 1'b1;
          pend_d  = p_targets;
          fsm_d   = (|p_targets) ? F_SEND : F_REPLY;
        end
      end
      F_SEND: begin
        pend_d  = pend_q & ~pick_oh;
        outst_d = outst_d | pick_oh;
        if (pend_d == '0) fsm_d = F_WAIT;
      end
      F_WAIT: begin
        if (outst_q == '0) fsm_d = F_REPLY;
      end
      F_REPLY: begin
        ent_we = 1'b1;
        fsm_d  = F_IDLE;
      end
      default: fsm_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm_q   <= F_IDLE;
      pend_q  <= '0;
      outst_q <= '0;
    end else begin
      fsm_q   <= fsm_d;
      pend_q  <= pend_d;
      outst_q <= outst_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      r_type_q <= req_type;
      r_node_q <= req_node;
      r_addr_q <= req_addr;
      r_data_q <= req_data;
    end
  end

  always_ff @(posedge clk) begin
    if (plan_en) begin
      plan_st_q  <= p_state;
      plan_shr_q <= p_shr;
      kind_q     <= p_kind;
    end
  end

  assign req_ready = (fsm_q == F_IDLE);
  assign rsp_valid = ((fsm_q == F_SEND) && pick_found) || (fsm_q == F_REPLY);
  assign rsp_kind  = (fsm_q == F_REPLY) ? RK_REPLY : kind_q;
  assign rsp_node  = (fsm_q == F_SEND) ? pick_idx : r_node_q;
  assign rsp_addr  = r_addr_q;
  assign rsp_data  = (fsm_q == F_REPLY) ? rd_data : '0;

endmodule

// File: rtl/dir_home_checker.sv
module dir_home_checker
  import dir_pkg::*;
#(
  parameter int NODE_CNT = 4,
  localparam int NODE_W  = (NODE_CNT > 1) ? $clog2(NODE_CNT) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic                rsp_valid,
  input logic [1:0]          rsp_kind,
  input logic [NODE_W-1:0]   rsp_node,
  input logic                ent_we,
  input dstate_t             ent_wstate,
  input logic [NODE_CNT-1:0] ent_wshr,
  input logic [NODE_W-1:0]   r_node_q
);

  // R3, R4, R6: a Modified block has exactly one owner
  p_mod_one_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_we && ent_wstate == DS_MOD) |-> ($countones(ent_wshr) == 1));

  // R7: Uncached blocks carry an empty presence vector
  p_unc_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_we && ent_wstate == DS_UNC) |-> (ent_wshr == '0));

  // R2: a Shared block has at least one sharer
  p_shr_nonempty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_we && ent_wstate == DS_SHR) |-> (ent_wshr != '0));

  // R4: the requester never receives its own invalidate
  p_inv_skip_self_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == RK_INV) |-> (rsp_node != r_node_q));

  // R9: accepting a request closes the request channel
  p_accept_closes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R9: a reply ends the transaction and reopens the channel
  p_reply_reopens_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == RK_REPLY) |=> req_ready);

  // R9: no response while the controller is idle
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rsp_valid);

endmodule

bind dir_home_ctrl dir_home_checker #(.NODE_CNT(NODE_CNT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_kind  (rsp_kind),
  .rsp_node  (rsp_node),
  .ent_we    (ent_we),
  .ent_wstate(ent_wstate),
  .ent_wshr  (ent_wshr),
  .r_node_q  (r_node_q)
);

// File: tb/dir_home_ctrl_bench.sv
`timescale 1ns/1ps
module dir_home_ctrl_bench;

  localparam int NODE_W = 2;
  localparam int ADDR_W = 4;

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic              req_ready;
  logic [1:0]        req_type;
  logic [NODE_W-1:0] req_node;
  logic [ADDR_W-1:0] req_addr;
  logic [31:0]       req_data;
  logic              rsp_valid;
  logic [1:0]        rsp_kind;
  logic [NODE_W-1:0] rsp_node;
  logic [ADDR_W-1:0] rsp_addr;
  logic [31:0]       rsp_data;
  logic              ack_valid;
  logic [NODE_W-1:0] ack_node;
  logic [31:0]       ack_data;

  dir_home_ctrl u_dir_home_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type),
    .req_node(req_node), .req_addr(req_addr), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_node(rsp_node),
    .rsp_addr(rsp_addr), .rsp_data(rsp_data),
    .ack_valid(ack_valid), .ack_node(ack_node), .ack_data(ack_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit reported = 0;

  // captured responses of the last transaction
  int          nr;
  int          rk [32];
  int          rn [32];
  int          ra [32];
  logic [31:0] rd [32];
  int          reply_cyc, last_ack_cyc, busy_err;
  int          aq_node [16];
  int          aq_time [16];

  function automatic logic [31:0] fdat(int node, int addr);
    return 32'hF000_0000 | (node << 8) | addr;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
    end
  endtask

  // typ: 0 read, 1 write, 2 writeback
  task automatic run_txn(int typ, int node, int addr, logic [31:0] data,
                         int ack_delay, int stray);
    int cyc, aq_n, aq_h;
    bit seen_reply;
    nr = 0; reply_cyc = -1; last_ack_cyc = -1; busy_err = 0;
    aq_n = 0; aq_h = 0; seen_reply = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_type  = 2'(typ);
    req_node  = NODE_W'(node);
    req_addr  = ADDR_W'(addr);
    req_data  = data;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    while (cyc < 60) begin
      if (rsp_valid && nr < 32) begin
        rk[nr] = int'(rsp_kind); rn[nr] = int'(rsp_node);
        ra[nr] = int'(rsp_addr); rd[nr] = rsp_data;
        if (rsp_kind != 2'd0) begin
          aq_node[aq_n] = int'(rsp_node);
          aq_time[aq_n] = cyc + 1 + ack_delay;
          aq_n++;
        end else begin
          seen_reply = 1;
          reply_cyc = cyc;
        end
        nr++;
      end
      if (typ != 2 && !seen_reply && req_ready) busy_err++;
      if (seen_reply) break;
      if (typ == 2 && cyc >= 6) break;
      ack_valid = 1'b0;
      if (aq_h < aq_n && aq_time[aq_h] <= cyc) begin
        ack_valid = 1'b1;
        ack_node  = NODE_W'(aq_node[aq_h]);
        ack_data  = fdat(aq_node[aq_h], addr);
        last_ack_cyc = cyc;
        aq_h++;
      end else if (stray >= 0 && cyc == 2) begin
        ack_valid = 1'b1;
        ack_node  = NODE_W'(stray);
        ack_data  = 32'h5757_5757;
      end
      @(negedge clk);
      ack_valid = 1'b0;
      cyc++;
    end
  endtask

  task automatic exp_rsp(int i, int kind, int node, int addr, logic [31:0] d,
                         bit use_d, string req);
    chk(nr > i, req, "response present", nr, i + 1);
    if (nr > i) begin
      chk(rk[i] == kind && rn[i] == node && ra[i] == addr, req, "kind/node/addr",
          (rk[i] << 16) | (rn[i] << 8) | ra[i], (kind << 16) | (node << 8) | addr);
      if (use_d) chk(rd[i] == d, req, "reply data", rd[i], d);
    end
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
    run_txn(0, 0, 0, 0, 0, -1);
    chk(nr == 1, "R2", "single reply on uncached read", nr, 1);
    exp_rsp(0, 0, 0, 0, 32'h0, 1, "R1");
  endtask

  task automatic t_read_then_invalidate();
    run_txn(0, 0, 1, 0, 0, -1);
    exp_rsp(0, 0, 0, 1, 32'h0, 1, "R2");
    run_txn(0, 2, 1, 0, 0, -1);
    chk(nr == 1, "R2", "shared read gives one reply", nr, 1);
    run_txn(1, 1, 1, 0, 0, -1);
    chk(nr == 3, "R4", "two invalidates then reply", nr, 3);
    exp_rsp(0, 1, 0, 1, 0, 0, "R4");
    exp_rsp(1, 1, 2, 1, 0, 0, "R4");
    exp_rsp(2, 0, 1, 1, 32'h0, 1, "R4");
  endtask

  task automatic t_write_by_sharer();
    run_txn(0, 1, 2, 0, 0, -1);
    run_txn(0, 3, 2, 0, 0, -1);
    run_txn(1, 3, 2, 0, 0, -1);
    chk(nr == 2, "R4", "requester not invalidated", nr, 2);
    exp_rsp(0, 1, 1, 2, 0, 0, "R4");
    exp_rsp(1, 0, 3, 2, 32'h0, 1, "R4");
  endtask

  task automatic t_write_uncached_read_modified();
    run_txn(1, 2, 3, 0, 0, -1);
    chk(nr == 1, "R3", "write to uncached replies only", nr, 1);
    exp_rsp(0, 0, 2, 3, 32'h0, 1, "R3");
    run_txn(0, 0, 3, 0, 1, -1);
    chk(nr == 2, "R5", "fetch then reply", nr, 2);
    exp_rsp(0, 2, 2, 3, 0, 0, "R5");
    exp_rsp(1, 0, 0, 3, fdat(2, 3), 1, "R5");
    run_txn(1, 1, 3, 0, 0, -1);
    chk(nr == 3, "R5", "both owner and reader are sharers", nr, 3);
    exp_rsp(0, 1, 0, 3, 0, 0, "R5");
    exp_rsp(1, 1, 2, 3, 0, 0, "R5");
    exp_rsp(2, 0, 1, 3, fdat(2, 3), 1, "R5");
  endtask

  task automatic t_write_modified();
    run_txn(1, 0, 4, 0, 0, -1);
    run_txn(1, 3, 4, 0, 0, -1);
    chk(nr == 2, "R6", "fetch-invalidate then reply", nr, 2);
    exp_rsp(0, 3, 0, 4, 0, 0, "R6");
    exp_rsp(1, 0, 3, 4, fdat(0, 4), 1, "R6");
    run_txn(0, 1, 4, 0, 0, -1);
    exp_rsp(0, 2, 3, 4, 0, 0, "R6");
    exp_rsp(1, 0, 1, 4, fdat(3, 4), 1, "R6");
  endtask

  task automatic t_writeback();
    run_txn(1, 1, 5, 0, 0, -1);
    run_txn(2, 1, 5, 32'hA5A5_0005, 0, -1);
    chk(nr == 0, "R7", "writeback is silent", nr, 0);
    run_txn(0, 2, 5, 0, 0, -1);
    chk(nr == 1, "R7", "block uncached after writeback", nr, 1);
    exp_rsp(0, 0, 2, 5, 32'hA5A5_0005, 1, "R7");
  endtask

  task automatic t_writeback_ignored();
    run_txn(1, 1, 6, 0, 0, -1);
    run_txn(2, 2, 6, 32'hDEAD_0006, 0, -1);
    chk(nr == 0, "R8", "non-owner writeback silent", nr, 0);
    run_txn(0, 0, 6, 0, 0, -1);
    chk(nr == 2, "R8", "owner still fetched", nr, 2);
    exp_rsp(0, 2, 1, 6, 0, 0, "R8");
    exp_rsp(1, 0, 0, 6, fdat(1, 6), 1, "R8");
    run_txn(2, 0, 0, 32'hBEEF_0000, 0, -1);
    chk(nr == 0, "R8", "shared writeback silent", nr, 0);
    run_txn(0, 3, 0, 0, 0, -1);
    chk(nr == 1, "R8", "shared read after ignored writeback", nr, 1);
    exp_rsp(0, 0, 3, 0, 32'h0, 1, "R8");
  endtask

  task automatic t_hold();
    run_txn(0, 0, 7, 0, 0, -1);
    run_txn(0, 1, 7, 0, 0, -1);
    run_txn(1, 2, 7, 0, 4, 3);
    chk(nr == 3, "R9", "responses with delayed acks", nr, 3);
    chk(busy_err == 0, "R9", "req_ready low while busy", busy_err, 0);
    chk(reply_cyc > last_ack_cyc, "R9", "reply after last awaited ack",
        reply_cyc, last_ack_cyc + 1);
    exp_rsp(2, 0, 2, 7, 32'h0, 1, "R9");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_type = '0; req_node = '0; req_addr = '0; req_data = '0;
    ack_valid = 1'b0; ack_node = '0; ack_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_then_invalidate();
    t_write_by_sharer();
    t_write_uncached_read_modified();
    t_write_modified();
    t_writeback();
    t_writeback_ignored();
    t_hold();
    report();
    $finish;
  end

endmodule